// File: doc/BRIEF.md
# AXI QoS Traffic Class Mapper

This block sits beside one AXI port of a memory controller. It converts the 4-bit QoS field carried on each read or write address beat into a traffic class, a region index and an aging timeout. The queues and the scheduler downstream use these results. All boundaries, classes and timeouts come in as static configuration inputs, and software may change them at run time.

On the read side, one level divides the QoS range into a lower and an upper region. Each region is given one of three read classes. A read whose class is high priority takes the timeout of the low-latency queue. Any other read takes the timeout of the normal queue. On the write side, two ordered levels divide the range into three regions. Each region is given a normal or a variable-priority write class. The topmost region has its own timeout, and the other two regions share one timeout.

The results are registered and appear on the clock edge after the address beat. The block also checks the configuration on every cycle. When it finds an illegal setting it raises a flag and degrades in a defined way.

Top module: `qos_class_mapper`

## Requirements
- R1: While rst_n is low at a clock edge, every output register clears to zero. This covers both out_valid flags, all classes, regions and timeouts, and config_error.
- R2: A read beat (rd_valid high) at edge k gives rd_out_valid high after edge k. rd_out_region is 0 when rd_qos <= cfg_rd_level and 1 otherwise. rd_out_class is cfg_rd_cls0 for region 0 and cfg_rd_cls1 for region 1. The encoding is 0 low, 1 variable, 2 high priority.
- R3: A read class programmed to the reserved code 3 is output as 0 (low priority), and config_error is raised.
- R4: rd_out_timeout is cfg_rd_tmo_hi when the output read class is 2, and cfg_rd_tmo_lo otherwise.
- R5: With a legal write configuration, wr_out_region is 0 for qos <= level1, 1 for level1 < qos <= level2, and 2 for qos > level2.
- R6: wr_out_class is cfg_wr_cls0, cfg_wr_cls1 or cfg_wr_cls2 for region 0, 1 or 2. Code 0 is normal and code 1 is variable priority.
- R7: wr_out_timeout is cfg_wr_tmo_top in region 2 and cfg_wr_tmo_low in regions 0 and 1.
- R8: A write configuration is illegal when cfg_wr_level2 <= cfg_wr_level1 or cfg_wr_level2 > 14. While it is illegal, config_error is raised and every write beat maps to region 0 with class cfg_wr_cls0 and timeout cfg_wr_tmo_low.
- R9: cfg_rd_level = 15 is illegal and raises config_error. Every read then falls in region 0.
- R10: A cycle without a beat on a channel drives that channel's out_valid low after the edge. The class, region and timeout of that channel keep their last values.
- R11: config_error is registered. It reflects the configuration present at the previous clock edge and clears once the configuration is legal again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd_level | input | 4 | Highest QoS value of read region 0 |
| cfg_rd_cls0 | input | 2 | Read class of region 0 |
| cfg_rd_cls1 | input | 2 | Read class of region 1 |
| cfg_rd_tmo_lo | input | 11 | Timeout for reads of low or variable class |
| cfg_rd_tmo_hi | input | 11 | Timeout for reads of high class |
| cfg_wr_level1 | input | 4 | Highest QoS value of write region 0 |
| cfg_wr_level2 | input | 4 | Highest QoS value of write region 1 |
| cfg_wr_cls0 | input | 1 | Write class of region 0 |
| cfg_wr_cls1 | input | 1 | Write class of region 1 |
| cfg_wr_cls2 | input | 1 | Write class of region 2 |
| cfg_wr_tmo_low | input | 11 | Write timeout for regions 0 and 1 |
| cfg_wr_tmo_top | input | 11 | Write timeout for region 2 |
| rd_valid | input | 1 | Read address beat present |
| rd_qos | input | 4 | QoS of the read beat |
| wr_valid | input | 1 | Write address beat present |
| wr_qos | input | 4 | QoS of the write beat |
| rd_out_valid | output | 1 | Read result valid |
| rd_out_class | output | 2 | Read traffic class |
| rd_out_region | output | 1 | Read region index |
| rd_out_timeout | output | 11 | Read aging timeout |
| wr_out_valid | output | 1 | Write result valid |
| wr_out_class | output | 1 | Write traffic class |
| wr_out_region | output | 2 | Write region index |
| wr_out_timeout | output | 11 | Write aging timeout |
| config_error | output | 1 | Configuration illegal at the previous edge |

## Verification
Each result register is written on the edge after its beat, so a wrong comparison or a wrong class select is visible at the ports one cycle after the faulty beat. A level compared off by one shows up only at QoS values equal to a level. For that reason the directed cases sit on those edges, at level 0, 13, 14 and 15. A fault in the legality logic shows up in two places. config_error is wrong one cycle later, and on an illegal write setting the write region moves away from 0 on the next write beat. A fault in the hold path shows up as a class or timeout that changes on a cycle without a beat.

// File: rtl/qos_map_pkg.sv
// Shared class encodings for the QoS traffic class mapper.
// Assumes: the encodings are fixed by the downstream queues and do not scale.
package qos_map_pkg;

    // Read traffic classes; code 3 is reserved and never leaves the block
    typedef enum logic [1:0] {
        RD_LOW  = 2'd0,
        RD_VAR  = 2'd1,
        RD_HIGH = 2'd2,
        RD_RSVD = 2'd3
    } rd_class_e;

    // Write traffic classes
    typedef enum logic {
        WR_NORM = 1'b0,
        WR_VAR  = 1'b1
    } wr_class_e;

    localparam int unsigned RD_CLS_W = 2;

endpackage

// File: rtl/qos_cfg_check.sv
// Combinational legality check of the mapper configuration.
// Assumes: levels are unsigned QoS values; the highest legal level is the
// QoS maximum minus one, so the top region is never empty.
module qos_cfg_check
    import qos_map_pkg::*;
#(
    parameter int unsigned QOS_W = 4
) (
    input  logic [QOS_W-1:0]    rd_level,
    input  logic [RD_CLS_W-1:0] rd_cls0,
    input  logic [RD_CLS_W-1:0] rd_cls1,
    input  logic [QOS_W-1:0]    wr_level1,
    input  logic [QOS_W-1:0]    wr_level2,
    output logic                rd_bad,
    output logic                wr_bad
);

    localparam logic [QOS_W-1:0] MAX_LVL = QOS_W'((1 << QOS_W) - 2);

    // Read side: reserved class code or a level that leaves region 1 empty
    always_comb begin
        rd_bad = (rd_cls0 == RD_RSVD) || (rd_cls1 == RD_RSVD) || (rd_level > MAX_LVL);
    end

    // Write side: levels must rise strictly and leave region 2 non-empty
    always_comb begin
        wr_bad = (wr_level2 <= wr_level1) || (wr_level2 > MAX_LVL);
    end

endmodule

// File: rtl/qos_rd_mapper.sv
// Read channel: one level splits QoS into two regions, each with a class;
// the high class selects the low-latency queue timeout.
// Assumes: reserved class code is folded to the low class here; result
// registers hold their data when no beat arrives.
module qos_rd_mapper
    import qos_map_pkg::*;
#(
    parameter int unsigned QOS_W = 4,
    parameter int unsigned TMO_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [QOS_W-1:0]    in_qos,
    input  logic [QOS_W-1:0]    level,
    input  logic [RD_CLS_W-1:0] cls0,
    input  logic [RD_CLS_W-1:0] cls1,
    input  logic [TMO_W-1:0]    tmo_lo,
    input  logic [TMO_W-1:0]    tmo_hi,
    output logic                out_valid,
    output logic [RD_CLS_W-1:0] out_class,
    output logic                out_region,
    output logic [TMO_W-1:0]    out_tmo
);

    logic                region_d;
    logic [RD_CLS_W-1:0] raw_cls;
    logic [RD_CLS_W-1:0] cls_d;
    logic [TMO_W-1:0]    tmo_d;

    // Region select: above the level means region 1
    always_comb begin
        region_d = (in_qos > level);
        raw_cls  = region_d ? cls1 : cls0;
    end

    // Class sanitising and timeout select
    always_comb begin
        cls_d = (raw_cls == RD_RSVD) ? RD_LOW : raw_cls;
        tmo_d = (cls_d == RD_HIGH) ? tmo_hi : tmo_lo;
    end

    // Result registers: valid follows the beat, data loads only on a beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_class  <= '0;
            out_region <= 1'b0;
            out_tmo    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_class  <= cls_d;
                out_region <= region_d;
                out_tmo    <= tmo_d;
            end
        end
    end

endmodule

// File: rtl/qos_wr_mapper.sv
// Write channel: NUM_REG-1 ordered levels split QoS into NUM_REG regions;
// the region index is the number of levels the QoS value lies above.
// Assumes: levels are ordered when cfg_bad is low; when cfg_bad is high the
// whole range falls back to region 0. The last region has its own timeout.
module qos_wr_mapper
    import qos_map_pkg::*;
#(
    parameter int unsigned QOS_W   = 4,
    parameter int unsigned TMO_W   = 11,
    parameter int unsigned NUM_REG = 3,
    localparam int unsigned REG_W  = $clog2(NUM_REG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [QOS_W-1:0]              in_qos,
    input  logic [NUM_REG-2:0][QOS_W-1:0] levels,
    input  logic [NUM_REG-1:0]            classes,
    input  logic                          cfg_bad,
    input  logic [TMO_W-1:0]              tmo_low,
    input  logic [TMO_W-1:0]              tmo_top,
    output logic                          out_valid,
    output logic                          out_class,
    output logic [REG_W-1:0]              out_region,
    output logic [TMO_W-1:0]              out_tmo
);

    localparam logic [REG_W-1:0] TOP_REG = REG_W'(NUM_REG - 1);

    logic [NUM_REG-2:0] above;
    logic [REG_W-1:0]   count;
    logic [REG_W-1:0]   region_d;
    logic               cls_d;
    logic [TMO_W-1:0]   tmo_d;

    // One comparator per level boundary
    for (genvar g = 0; g < NUM_REG - 1; g++) begin : g_bound
        assign above[g] = (in_qos > levels[g]);
    end

    // Region index: number of boundaries passed, or 0 on illegal levels
    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_REG - 1; i++) begin
            count = count + REG_W'(above[i]);
        end
        region_d = cfg_bad ? '0 : count;
    end

    // Class and timeout of the selected region
    always_comb begin
        cls_d = classes[region_d];
        tmo_d = (region_d == TOP_REG) ? tmo_top : tmo_low;
    end

    // Result registers: valid follows the beat, data loads only on a beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_class  <= WR_NORM;
            out_region <= '0;
            out_tmo    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_class  <= cls_d;
                out_region <= region_d;
                out_tmo    <= tmo_d;
            end
        end
    end

endmodule

// File: rtl/qos_class_mapper.sv
// Per-port QoS to traffic class mapper, read and write channels.
// Assumes: configuration inputs are quasi-static register outputs; each
// beat is mapped with the configuration present at its own clock edge.
module qos_class_mapper
    import qos_map_pkg::*;
#(
    parameter int unsigned QOS_W = 4,
    parameter int unsigned TMO_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [QOS_W-1:0]    cfg_rd_level,
    input  logic [RD_CLS_W-1:0] cfg_rd_cls0,
    input  logic [RD_CLS_W-1:0] cfg_rd_cls1,
    input  logic [TMO_W-1:0]    cfg_rd_tmo_lo,
    input  logic [TMO_W-1:0]    cfg_rd_tmo_hi,
    input  logic [QOS_W-1:0]    cfg_wr_level1,
    input  logic [QOS_W-1:0]    cfg_wr_level2,
    input  logic                cfg_wr_cls0,
    input  logic                cfg_wr_cls1,
    input  logic                cfg_wr_cls2,
    input  logic [TMO_W-1:0]    cfg_wr_tmo_low,
    input  logic [TMO_W-1:0]    cfg_wr_tmo_top,
    input  logic                rd_valid,
    input  logic [QOS_W-1:0]    rd_qos,
    input  logic                wr_valid,
    input  logic [QOS_W-1:0]    wr_qos,
    output logic                rd_out_valid,
    output logic [RD_CLS_W-1:0] rd_out_class,
    output logic                rd_out_region,
    output logic [TMO_W-1:0]    rd_out_timeout,
    output logic                wr_out_valid,
    output logic                wr_out_class,
    output logic [1:0]          wr_out_region,
    output logic [TMO_W-1:0]    wr_out_timeout,
    output logic                config_error
);

    localparam int unsigned WR_REGIONS = 3;

    logic                                rd_bad;
    logic                                wr_bad;
    logic [WR_REGIONS-2:0][QOS_W-1:0]    wr_levels;
    logic [WR_REGIONS-1:0]               wr_classes;

    // Pack write boundaries and classes in region order
    always_comb begin
        wr_levels  = {cfg_wr_level2, cfg_wr_level1};
        wr_classes = {cfg_wr_cls2, cfg_wr_cls1, cfg_wr_cls0};
    end

    qos_cfg_check #(.QOS_W(QOS_W)) u_check (
        .rd_level  (cfg_rd_level),
        .rd_cls0   (cfg_rd_cls0),
        .rd_cls1   (cfg_rd_cls1),
        .wr_level1 (cfg_wr_level1),
        .wr_level2 (cfg_wr_level2),
        .rd_bad    (rd_bad),
        .wr_bad    (wr_bad)
    );

    qos_rd_mapper #(.QOS_W(QOS_W), .TMO_W(TMO_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rd_valid),
        .in_qos     (rd_qos),
        .level      (cfg_rd_level),
        .cls0       (cfg_rd_cls0),
        .cls1       (cfg_rd_cls1),
        .tmo_lo     (cfg_rd_tmo_lo),
        .tmo_hi     (cfg_rd_tmo_hi),
        .out_valid  (rd_out_valid),
        .out_class  (rd_out_class),
        .out_region (rd_out_region),
        .out_tmo    (rd_out_timeout)
    );

    qos_wr_mapper #(.QOS_W(QOS_W), .TMO_W(TMO_W), .NUM_REG(WR_REGIONS)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (wr_valid),
        .in_qos     (wr_qos),
        .levels     (wr_levels),
        .classes    (wr_classes),
        .cfg_bad    (wr_bad),
        .tmo_low    (cfg_wr_tmo_low),
        .tmo_top    (cfg_wr_tmo_top),
        .out_valid  (wr_out_valid),
        .out_class  (wr_out_class),
        .out_region (wr_out_region),
        .out_tmo    (wr_out_timeout)
    );

    // Registered configuration error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            config_error <= 1'b0;
        end else begin
            config_error <= rd_bad || wr_bad;
        end
    end

endmodule

// File: rtl/qos_class_mapper_chk.sv
// Assertion checker for qos_class_mapper, attached by bind.
// Assumes: port names match the top module so that .* binds them.
module qos_class_mapper_chk #(
    parameter int unsigned QOS_W = 4,
    parameter int unsigned TMO_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [QOS_W-1:0] cfg_rd_level,
    input logic [1:0]       cfg_rd_cls0,
    input logic [1:0]       cfg_rd_cls1,
    input logic [QOS_W-1:0] cfg_wr_level1,
    input logic [QOS_W-1:0] cfg_wr_level2,
    input logic             rd_valid,
    input logic [QOS_W-1:0] rd_qos,
    input logic             wr_valid,
    input logic             rd_out_valid,
    input logic [1:0]       rd_out_class,
    input logic             rd_out_region,
    input logic [TMO_W-1:0] rd_out_timeout,
    input logic             wr_out_valid,
    input logic             wr_out_class,
    input logic [1:0]       wr_out_region,
    input logic [TMO_W-1:0] wr_out_timeout,
    input logic             config_error
);

    localparam logic [QOS_W-1:0] TOP_LVL = QOS_W'((1 << QOS_W) - 2);

    logic wr_levels_bad;
    logic rd_cfg_bad;

    // Independent view of the legality rules
    always_comb begin
        wr_levels_bad = !(cfg_wr_level1 < cfg_wr_level2) || (cfg_wr_level2 > TOP_LVL);
        rd_cfg_bad    = (cfg_rd_cls0 == 2'd3) || (cfg_rd_cls1 == 2'd3) || (cfg_rd_level > TOP_LVL);
    end

    p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_out_valid);

    p_rd_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (rd_out_region == ($past(rd_qos) > $past(cfg_rd_level))));

    p_no_reserved_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_valid |-> (rd_out_class != 2'd3));

    p_wr_region_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out_valid |-> (wr_out_region <= 2'd2));

    p_wr_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_levels_bad) |=> (wr_out_region == 2'd0));

    p_cfg_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (config_error == $past(wr_levels_bad || rd_cfg_bad)));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!rd_out_valid && $stable(rd_out_class) && $stable(rd_out_timeout)));

    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (!wr_out_valid && $stable(wr_out_region) && $stable(wr_out_class)
                       && $stable(wr_out_timeout)));

endmodule

bind qos_class_mapper qos_class_mapper_chk #(.QOS_W(QOS_W), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/qos_class_mapper_tb.sv
module qos_class_mapper_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_rd_level;
    logic [1:0]  cfg_rd_cls0, cfg_rd_cls1;
    logic [10:0] cfg_rd_tmo_lo, cfg_rd_tmo_hi;
    logic [3:0]  cfg_wr_level1, cfg_wr_level2;
    logic        cfg_wr_cls0, cfg_wr_cls1, cfg_wr_cls2;
    logic [10:0] cfg_wr_tmo_low, cfg_wr_tmo_top;
    logic        rd_valid, wr_valid;
    logic [3:0]  rd_qos, wr_qos;
    logic        rd_out_valid, rd_out_region, wr_out_valid, wr_out_class, config_error;
    logic [1:0]  rd_out_class, wr_out_region;
    logic [10:0] rd_out_timeout, wr_out_timeout;

    int checks = 0;
    int errors = 0;

    // expected held state
    int e_rcls = 0, e_rreg = 0, e_rtmo = 0;
    int e_wcls = 0, e_wreg = 0, e_wtmo = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qos_class_mapper u_dut (.*);

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit rd_bad();
        return (cfg_rd_cls0 == 2'd3) || (cfg_rd_cls1 == 2'd3) || (cfg_rd_level == 4'd15);
    endfunction

    function automatic bit wr_bad();
        return (int'(cfg_wr_level2) <= int'(cfg_wr_level1)) || (cfg_wr_level2 > 4'd14);
    endfunction

    function automatic int exp_rreg(int q);
        return (q > int'(cfg_rd_level)) ? 1 : 0;
    endfunction

    function automatic int exp_rcls(int q);
        int c;
        c = (exp_rreg(q) == 1) ? int'(cfg_rd_cls1) : int'(cfg_rd_cls0);
        return (c == 3) ? 0 : c;
    endfunction

    function automatic int exp_wreg(int q);
        if (wr_bad()) return 0;
        if (q <= int'(cfg_wr_level1)) return 0;
        if (q <= int'(cfg_wr_level2)) return 1;
        return 2;
    endfunction

    function automatic int exp_wcls(int r);
        return (r == 0) ? int'(cfg_wr_cls0) : (r == 1) ? int'(cfg_wr_cls1) : int'(cfg_wr_cls2);
    endfunction

    // One cycle: drive at negedge, compute expectations, sample 1 after posedge
    task automatic step(bit rv, int rq, bit wv, int wq);
        bit e_err;
        @(negedge clk);
        rd_valid = rv; rd_qos = 4'(rq);
        wr_valid = wv; wr_qos = 4'(wq);
        #1;
        e_err = rd_bad() || wr_bad();
        if (rv) begin
            e_rreg = exp_rreg(rq);
            e_rcls = exp_rcls(rq);
            e_rtmo = (e_rcls == 2) ? int'(cfg_rd_tmo_hi) : int'(cfg_rd_tmo_lo);
        end
        if (wv) begin
            e_wreg = exp_wreg(wq);
            e_wcls = exp_wcls(e_wreg);
            e_wtmo = (e_wreg == 2) ? int'(cfg_wr_tmo_top) : int'(cfg_wr_tmo_low);
        end
        @(posedge clk);
        #1;
        check("R2/R10", "rd_out_valid", int'(rd_out_valid), int'(rv));
        check("R2/R9", "rd_out_region", int'(rd_out_region), e_rreg);
        check("R2/R3", "rd_out_class", int'(rd_out_class), e_rcls);
        check("R4", "rd_out_timeout", int'(rd_out_timeout), e_rtmo);
        check("R10", "wr_out_valid", int'(wr_out_valid), int'(wv));
        check("R5/R8", "wr_out_region", int'(wr_out_region), e_wreg);
        check("R6", "wr_out_class", int'(wr_out_class), e_wcls);
        check("R7", "wr_out_timeout", int'(wr_out_timeout), e_wtmo);
        check("R11", "config_error", int'(config_error), int'(e_err));
    endtask

    task automatic set_legal_cfg();
        int l1;
        cfg_rd_level  = 4'($urandom % 15);
        cfg_rd_cls0   = 2'($urandom % 3);
        cfg_rd_cls1   = 2'($urandom % 3);
        cfg_rd_tmo_lo = 11'($urandom);
        cfg_rd_tmo_hi = 11'($urandom);
        l1            = $urandom % 14;
        cfg_wr_level1 = 4'(l1);
        cfg_wr_level2 = 4'(l1 + 1 + int'($urandom % (14 - l1)));
        cfg_wr_cls0   = 1'($urandom);
        cfg_wr_cls1   = 1'($urandom);
        cfg_wr_cls2   = 1'($urandom);
        cfg_wr_tmo_low = 11'($urandom);
        cfg_wr_tmo_top = 11'($urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        set_legal_cfg();
        cfg_rd_cls0 = 2'd3;            // illegal during reset: flag must stay low
        rd_valid = 1'b1; wr_valid = 1'b1; rd_qos = 4'd15; wr_qos = 4'd15;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "rd_out_valid", int'(rd_out_valid), 0);
        check("R1", "rd_out_class", int'(rd_out_class), 0);
        check("R1", "rd_out_timeout", int'(rd_out_timeout), 0);
        check("R1", "wr_out_valid", int'(wr_out_valid), 0);
        check("R1", "wr_out_region", int'(wr_out_region), 0);
        check("R1", "wr_out_timeout", int'(wr_out_timeout), 0);
        check("R1", "config_error", int'(config_error), 0);
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        set_legal_cfg();
        rst_n = 1'b1;

        // R2 / R9 boundaries on the read level
        cfg_rd_cls0 = 2'd0; cfg_rd_cls1 = 2'd2;
        cfg_rd_level = 4'd0;  step(1, 0, 0, 0); step(1, 1, 0, 0);
        cfg_rd_level = 4'd14; step(1, 14, 0, 0); step(1, 15, 0, 0);
        cfg_rd_level = 4'd15; step(1, 15, 0, 0); step(1, 0, 0, 0);   // R9
        cfg_rd_level = 4'd7;
        // R3 reserved class folded to low
        cfg_rd_cls1 = 2'd3; step(1, 9, 0, 0); step(1, 3, 0, 0);
        cfg_rd_cls1 = 2'd1; step(1, 9, 0, 0);                       // R11 clears

        // R5-R7 write boundaries
        cfg_wr_cls0 = 1'b0; cfg_wr_cls1 = 1'b1; cfg_wr_cls2 = 1'b0;
        cfg_wr_level1 = 4'd0; cfg_wr_level2 = 4'd14;
        step(0, 0, 1, 0); step(0, 0, 1, 1); step(0, 0, 1, 14); step(0, 0, 1, 15);
        cfg_wr_level1 = 4'd13; cfg_wr_level2 = 4'd14;
        step(0, 0, 1, 13); step(0, 0, 1, 14); step(0, 0, 1, 15);
        // R8 illegal write levels: fallback to region 0
        cfg_wr_level1 = 4'd5; cfg_wr_level2 = 4'd5;  step(0, 0, 1, 15); step(0, 0, 1, 6);
        cfg_wr_level1 = 4'd2; cfg_wr_level2 = 4'd15; step(0, 0, 1, 15);
        cfg_wr_level1 = 4'd9; cfg_wr_level2 = 4'd3;  step(0, 0, 1, 12);
        // R10 idle cycles hold data while config changes
        set_legal_cfg();
        step(1, 4, 1, 4);
        set_legal_cfg();
        step(0, 11, 0, 11); step(0, 2, 0, 2);

        // Constrained random traffic
        for (int i = 0; i < 2000; i++) begin
            if (i % 10 == 0) begin
                set_legal_cfg();
                if ($urandom % 8 == 0) cfg_rd_cls0 = 2'd3;
                if ($urandom % 10 == 0) cfg_rd_level = 4'd15;
                if ($urandom % 6 == 0) cfg_wr_level2 = 4'($urandom);
            end
            step(($urandom % 4) != 0, int'($urandom % 16), ($urandom % 4) != 0, int'($urandom % 16));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule